// File: doc/BRIEF.md
# Capture-Mode Timer Channel

This block is one counter channel of a timer, running in input-capture mode. A 16-bit counter advances on edges of a count-enable input supplied by an external clock-source selector. On chosen edges of a capture input it copies the running count into two holding registers, A and B, which are filled strictly in the order A then B. This makes it straightforward to measure pulse widths, periods or phase between edges.

The counter can be restarted from zero by a software command, by an edge on either of two external inputs, or by a match against a programmable limit register C. Loading B can optionally halt the count until the next restart, or switch the clock off until software enables it again. Eight sticky event flags, each with its own mask bit, drive one interrupt line.

Software reaches the channel through a simple word-wide register port with a three-bit address. Register reads are combinational. A read of a capture register or of the flag register also acknowledges it.

Top module: `cap_timer`

## Requirements
- R1: After reset the count is 0, the clock is disabled but not halted, all flags and mask bits are 0 and `irq` is low. The flag register at address 6 therefore reads 0x0200.
- R2: While the clock is enabled and not halted, the count rises by one on each rising edge of `cnt_en`. When control bit 10 (invert) is set, it rises on each falling edge instead. At any other time the count holds.
- R3: Writing address 1 with bit 0 enables the clock and with bit 1 disables it. If both bits are set in one write, the clock ends up disabled. Bit 8 of the flag register shows the enable state.
- R4: Loads of A and of B are taken on `cap_a_in` edges chosen by 2-bit codes. The A code is in control bits 1:0 and the B code in bits 3:2. Code 0 means never, 1 rising, 2 falling and 3 either edge.
- R5: A loads only when no A capture is waiting for its B, and B loads only when one is. Any restart clears the waiting state. A is read at address 3 and B at address 4.
- R6: Loading A while the previous A value is unread, or loading B while the previous B value is unread, sets the overrun flag (bit 1). Reading the register marks its value as read.
- R7: Writing address 1 with bit 2 set clears the count to 0 and releases a halted clock. It does not change the enable state.
- R8: An external restart occurs on the `cap_a_in` edge (control bit 6 = 1) or on the `cap_b_in` edge (bit 6 = 0) that matches the code in bits 5:4. It clears the count and sets flag bit 7. Edges on the input that is not selected have no effect.
- R9: On each count step taken while the count equals A, B or C, flag bit 2, 3 or 4 is set. C is written and read at address 5. With control bit 7 set, a step taken at C loads 0 instead of C+1.
- R10: With control bit 8 set, loading B halts the count until the next restart. Flag register bit 9 reads 1 while the count is not halted.
- R11: With control bit 9 set, loading B disables the clock. Restarts do not re-enable it; only an enable command does.
- R12: A step from 0xFFFF wraps the count to 0 and sets flag bit 0.
- R13: The flag register at address 6 holds, from bit 0 upward: wrap, overrun, A match, B match, C match, A loaded, B loaded, external restart. Its flags stay set until the register is read, and a read clears them. An event in the same cycle as the read leaves its flag set.
- R14: `irq` is high exactly while some flag is set whose bit is set in the mask register at address 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count enable from the clock-source selector |
| cap_a_in | input | 1 | Capture input and restart source A |
| cap_b_in | input | 1 | Restart source B |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (acknowledges captures and flags) |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from `addr` |
| irq | output | 1 | Interrupt request |

## Verification
The bench walks every edge-code and edge-direction pair and checks that a capture is taken only where the code allows it. A wrong decode would load A on the wrong edge or miss a load.

It makes a second rising edge arrive while an A value is waiting for its B. A design without ordering would overwrite A at that point and never fill B. It then reloads A without a read in between, and the overrun flag must rise.

Three further cases are covered:
- The halt and disable options on a B load must differ in whether a restart revives the count.
- A flag-register read issued in the same cycle as a new capture must not lose that capture's flag.
- A full 65536-step run checks the wrap back to zero.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_code_t;

  typedef struct packed {
    logic       clk_inv;
    logic       dis_on_b;
    logic       stop_on_b;
    logic       c_trig_en;
    logic       trig_sel;
    logic [1:0] trig_edge;
    logic [1:0] b_edge;
    logic [1:0] a_edge;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int NFLAG  = 8;

  localparam logic [2:0] ADR_CTRL  = 3'd0;
  localparam logic [2:0] ADR_CMD   = 3'd1;
  localparam logic [2:0] ADR_COUNT = 3'd2;
  localparam logic [2:0] ADR_CAPA  = 3'd3;
  localparam logic [2:0] ADR_CAPB  = 3'd4;
  localparam logic [2:0] ADR_LIMC  = 3'd5;
  localparam logic [2:0] ADR_FLAGS = 3'd6;
  localparam logic [2:0] ADR_MASK  = 3'd7;

  localparam int FL_WRAP = 0;
  localparam int FL_OVR  = 1;
  localparam int FL_MA   = 2;
  localparam int FL_MB   = 3;
  localparam int FL_MC   = 4;
  localparam int FL_LDA  = 5;
  localparam int FL_LDB  = 6;
  localparam int FL_EXT  = 7;

  function automatic logic edge_match(input logic [1:0] code,
                                      input logic rise, input logic fall);
    case (edge_code_t'(code))
      EDGE_RISE: edge_match = rise;
      EDGE_FALL: edge_match = fall;
      EDGE_ANY:  edge_match = rise | fall;
      default:   edge_match = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det #(
  parameter int NSIG = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSIG-1:0] sig,
  output logic [NSIG-1:0] rise,
  output logic [NSIG-1:0] fall
);
  logic [NSIG-1:0] prev_q;

  for (genvar i = 0; i < NSIG; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= sig[i];
    end
    assign rise[i] = sig[i] & ~prev_q[i];
    assign fall[i] = ~sig[i] & prev_q[i];
  end
endmodule

// File: rtl/cap_counter.sv
module cap_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart_req,
  input  logic          cmd_en,
  input  logic          cmd_dis,
  input  logic          ld_b,
  input  logic          stop_on_b,
  input  logic          dis_on_b,
  input  logic          c_trig_en,
  input  logic [CW-1:0] reg_a,
  input  logic [CW-1:0] reg_b,
  input  logic [CW-1:0] reg_c,
  output logic [CW-1:0] count,
  output logic          clk_en,
  output logic          clk_run,
  output logic          adv,
  output logic          trig_any,
  output logic          wrap_ev,
  output logic          ma_ev,
  output logic          mb_ev,
  output logic          mc_ev
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic c_restart;

  assign adv       = tick & clk_en & clk_run;
  assign mc_ev     = adv && (count == reg_c);
  assign ma_ev     = adv && (count == reg_a);
  assign mb_ev     = adv && (count == reg_b);
  assign c_restart = mc_ev & c_trig_en;
  assign trig_any  = restart_req | c_restart;
  assign wrap_ev   = adv && (count == CNT_MAX) && !trig_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (trig_any) begin
      count <= '0;
    end else if (adv) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_en <= 1'b0;
    end else if (cmd_dis || (ld_b && dis_on_b)) begin
      clk_en <= 1'b0;
    end else if (cmd_en) begin
      clk_en <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_run <= 1'b1;
    end else if (ld_b && stop_on_b) begin
      clk_run <= 1'b0;
    end else if (trig_any) begin
      clk_run <= 1'b1;
    end
  end
endmodule

// File: rtl/cap_capture.sv
module cap_capture #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_rise,
  input  logic          in_fall,
  input  logic [1:0]    a_edge,
  input  logic [1:0]    b_edge,
  input  logic [CW-1:0] count,
  input  logic          trig_any,
  input  logic          rd_a,
  input  logic          rd_b,
  output logic [CW-1:0] reg_a,
  output logic [CW-1:0] reg_b,
  output logic          ld_a,
  output logic          ld_b,
  output logic          ovr_ev
);
  import cap_timer_pkg::*;

  logic wait_b_q;
  logic a_unread_q;
  logic b_unread_q;

  assign ld_a   = edge_match(a_edge, in_rise, in_fall) & ~wait_b_q;
  assign ld_b   = edge_match(b_edge, in_rise, in_fall) &  wait_b_q;
  assign ovr_ev = (ld_a & a_unread_q) | (ld_b & b_unread_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_a      <= '0;
      reg_b      <= '0;
      wait_b_q   <= 1'b0;
      a_unread_q <= 1'b0;
      b_unread_q <= 1'b0;
    end else begin
      if (ld_a) reg_a <= count;
      if (ld_b) reg_b <= count;

      if (ld_a)                 wait_b_q <= 1'b1;
      else if (ld_b || trig_any) wait_b_q <= 1'b0;

      if (ld_a)      a_unread_q <= 1'b1;
      else if (rd_a) a_unread_q <= 1'b0;

      if (ld_b)      b_unread_q <= 1'b1;
      else if (rd_b) b_unread_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cap_status.sv
module cap_status #(
  parameter int NF = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_vec,
  input  logic          rd_clr,
  input  logic          mask_wr,
  input  logic [NF-1:0] mask_d,
  output logic [NF-1:0] flags,
  output logic [NF-1:0] mask,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '0;
    end else begin
      flags <= (rd_clr ? '0 : flags) | set_vec;
      if (mask_wr) mask <= mask_d;
    end
  end

  assign irq = |(flags & mask);
endmodule

// File: rtl/cap_timer.sv
module cap_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          cap_a_in,
  input  logic          cap_b_in,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [2:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          irq
);
  import cap_timer_pkg::*;

  localparam int NSIG   = 3;
  localparam int SIG_CK = 0;
  localparam int SIG_A  = 1;
  localparam int SIG_B  = 2;

  ctrl_t           ctrl_q;
  logic [CW-1:0]   reg_c_q;
  logic [NSIG-1:0] rise, fall;
  logic            tick, ext_trig, restart_req;
  logic            cmd_en, cmd_dis, cmd_soft;
  logic            rd_a, rd_b, st_rd;
  logic [CW-1:0]   count, reg_a, reg_b;
  logic            clk_en, clk_run, adv, trig_any;
  logic            wrap_ev, ma_ev, mb_ev, mc_ev;
  logic            ld_a, ld_b, ovr_ev;
  logic [NFLAG-1:0] set_vec, flags, mask;
  logic            stop_on_b;
  logic            trig_rise, trig_fall;

  // register writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      reg_c_q <= '0;
    end else if (wr_en) begin
      if (addr == ADR_CTRL) ctrl_q  <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (addr == ADR_LIMC) reg_c_q <= wdata;
    end
  end

  assign cmd_en   = wr_en && (addr == ADR_CMD) && wdata[0];
  assign cmd_dis  = wr_en && (addr == ADR_CMD) && wdata[1];
  assign cmd_soft = wr_en && (addr == ADR_CMD) && wdata[2];
  assign rd_a     = rd_en && (addr == ADR_CAPA);
  assign rd_b     = rd_en && (addr == ADR_CAPB);
  assign st_rd    = rd_en && (addr == ADR_FLAGS);
  assign stop_on_b = ctrl_q.stop_on_b;

  cap_edge_det #(.NSIG(NSIG)) u_edges (
    .clk  (clk),
    .rst_n(rst_n),
    .sig  ({cap_b_in, cap_a_in, cnt_en}),
    .rise (rise),
    .fall (fall)
  );

  assign tick      = ctrl_q.clk_inv ? fall[SIG_CK] : rise[SIG_CK];
  assign trig_rise = ctrl_q.trig_sel ? rise[SIG_A] : rise[SIG_B];
  assign trig_fall = ctrl_q.trig_sel ? fall[SIG_A] : fall[SIG_B];
  assign ext_trig  = edge_match(ctrl_q.trig_edge, trig_rise, trig_fall);
  assign restart_req = ext_trig | cmd_soft;

  cap_counter #(.CW(CW)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .restart_req(restart_req),
    .cmd_en     (cmd_en),
    .cmd_dis    (cmd_dis),
    .ld_b       (ld_b),
    .stop_on_b  (ctrl_q.stop_on_b),
    .dis_on_b   (ctrl_q.dis_on_b),
    .c_trig_en  (ctrl_q.c_trig_en),
    .reg_a      (reg_a),
    .reg_b      (reg_b),
    .reg_c      (reg_c_q),
    .count      (count),
    .clk_en     (clk_en),
    .clk_run    (clk_run),
    .adv        (adv),
    .trig_any   (trig_any),
    .wrap_ev    (wrap_ev),
    .ma_ev      (ma_ev),
    .mb_ev      (mb_ev),
    .mc_ev      (mc_ev)
  );

  cap_capture #(.CW(CW)) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_rise (rise[SIG_A]),
    .in_fall (fall[SIG_A]),
    .a_edge  (ctrl_q.a_edge),
    .b_edge  (ctrl_q.b_edge),
    .count   (count),
    .trig_any(trig_any),
    .rd_a    (rd_a),
    .rd_b    (rd_b),
    .reg_a   (reg_a),
    .reg_b   (reg_b),
    .ld_a    (ld_a),
    .ld_b    (ld_b),
    .ovr_ev  (ovr_ev)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[FL_WRAP] = wrap_ev;
    set_vec[FL_OVR]  = ovr_ev;
    set_vec[FL_MA]   = ma_ev;
    set_vec[FL_MB]   = mb_ev;
    set_vec[FL_MC]   = mc_ev;
    set_vec[FL_LDA]  = ld_a;
    set_vec[FL_LDB]  = ld_b;
    set_vec[FL_EXT]  = ext_trig;
  end

  cap_status #(.NF(NFLAG)) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(set_vec),
    .rd_clr (st_rd),
    .mask_wr(wr_en && (addr == ADR_MASK)),
    .mask_d (wdata[NFLAG-1:0]),
    .flags  (flags),
    .mask   (mask),
    .irq    (irq)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      ADR_CTRL:  rdata[CTRL_W-1:0] = ctrl_q;
      ADR_COUNT: rdata = count;
      ADR_CAPA:  rdata = reg_a;
      ADR_CAPB:  rdata = reg_b;
      ADR_LIMC:  rdata = reg_c_q;
      ADR_FLAGS: rdata[NFLAG+1:0] = {clk_run, clk_en, flags};
      ADR_MASK:  rdata[NFLAG-1:0] = mask;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adv,
  input logic          trig_any,
  input logic [CW-1:0] count,
  input logic          clk_en,
  input logic          clk_run,
  input logic          cmd_dis,
  input logic          ld_a,
  input logic          ld_b,
  input logic          stop_on_b,
  input logic          st_rd,
  input logic [7:0]    flags
);
  logic [CW-1:0] cnt_inc;
  assign cnt_inc = count + 1'b1;

  // R2: count holds without a step or restart
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !trig_any) |=> (count == $past(count)));

  // R2: a step adds one
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !trig_any) |=> (count == $past(cnt_inc)));

  // R7: any restart clears the count
  p_restart_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_any |=> (count == '0));

  // R3: disable command always wins
  p_disable_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_dis |=> !clk_en);

  // R5: A and B never load in the same cycle
  p_one_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_a |-> !ld_b);

  // R10: B load with halt option stops the count
  p_halt_on_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_b && stop_on_b) |=> !clk_run);

  // R12: step from the top value wraps to zero
  p_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (count == {CW{1'b1}})) |=> (count == '0));

  // R13: flags never drop without a status read
  p_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !st_rd |=> (($past(flags) & ~flags) == 8'h00));
endmodule

bind cap_timer cap_timer_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .adv      (adv),
  .trig_any (trig_any),
  .count    (count),
  .clk_en   (clk_en),
  .clk_run  (clk_run),
  .cmd_dis  (cmd_dis),
  .ld_a     (ld_a),
  .ld_b     (ld_b),
  .stop_on_b(stop_on_b),
  .st_rd    (st_rd),
  .flags    (flags)
);

// File: tb/cap_timer_test.sv
module cap_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        cap_a_in = 1'b0;
  logic        cap_b_in = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cap_timer uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cap_a_in(cap_a_in),
    .cap_b_in(cap_b_in), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // edge table: {code[1:0], rising, expect_load}
  localparam logic [3:0] EDGE_VEC [8] = '{
    4'b0010, 4'b0000, 4'b0111, 4'b0100,
    4'b1010, 4'b1001, 4'b1111, 4'b1101
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt_en = 1'b1;
      @(negedge clk); cnt_en = 1'b0;
    end
  endtask

  task automatic set_a(input logic v);
    @(negedge clk); cap_a_in = v;
    @(negedge clk);
  endtask

  task automatic set_b(input logic v);
    @(negedge clk); cap_b_in = v;
    @(negedge clk);
  endtask

  task automatic soft_trig();
    wr(3'd1, 16'h0004);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd2, v); check("R1 count", v, 16'h0000);
    rd(3'd6, v); check("R1 flags", v, 16'h0200);
    check("R1 irq", {15'd0, irq}, 16'd0);

    // R3 disabled clock ignores pulses; disable beats enable
    pulse(3);
    rd(3'd2, v); check("R3 no count while disabled", v, 16'h0000);
    wr(3'd1, 16'h0003);
    rd(3'd6, v); check("R3 disable wins", v & 16'h0100, 16'h0000);
    wr(3'd1, 16'h0001);
    rd(3'd6, v); check("R3 enabled", v & 16'h0100, 16'h0100);

    // R2 counting on rising edges
    pulse(3);
    rd(3'd2, v); check("R2 rising count", v, 16'd3);

    // R2 invert: counts on falling edge
    wr(3'd0, 16'h0400);
    @(negedge clk); cnt_en = 1'b1;
    rd(3'd2, v); check("R2 invert no step on rise", v, 16'd3);
    @(negedge clk); cnt_en = 1'b0;
    rd(3'd2, v); check("R2 invert step on fall", v, 16'd4);

    // R4 edge-code table on A
    for (int i = 0; i < 8; i++) begin
      logic [3:0] e;
      e = EDGE_VEC[i];
      wr(3'd0, {14'd0, e[3:2]});
      set_a(!e[1]);
      soft_trig();
      rd(3'd6, v);
      pulse(i + 1);
      set_a(e[1]);
      rd(3'd6, v); check("R4 A load on coded edge", (v >> 5) & 16'h1, {15'd0, e[0]});
      if (e[0]) begin
        rd(3'd3, v); check("R4 A value", v, 16'(i + 1));
      end
    end

    // R5 ordering and R6 overrun; A=rise, B=rise
    wr(3'd0, 16'h0005);
    soft_trig();
    rd(3'd6, v);
    rd(3'd4, v);
    pulse(3);
    set_a(1'b1);
    set_a(1'b0);
    pulse(2);
    set_a(1'b1);
    rd(3'd6, v); check("R5 both loaded, no overrun", v & 16'h0062, 16'h0060);
    rd(3'd3, v); check("R5 A kept first capture", v, 16'd3);
    rd(3'd4, v); check("R5 B took second edge", v, 16'd5);
    set_a(1'b0);
    pulse(1);
    set_a(1'b1);
    set_a(1'b0);
    pulse(1);
    set_a(1'b1);
    rd(3'd6, v); check("R6 no overrun after reads", v & 16'h0002, 16'h0000);
    set_a(1'b0);
    pulse(1);
    set_a(1'b1);
    rd(3'd6, v); check("R6 overrun on unread A", v & 16'h0002, 16'h0002);
    rd(3'd3, v); check("R6 A reloaded", v, 16'd8);

    // R10 halt on B load, R7 soft restart
    wr(3'd0, 16'h0105);
    rd(3'd4, v);
    soft_trig();
    set_a(1'b0);
    pulse(2);
    set_a(1'b1);
    set_a(1'b0);
    pulse(1);
    set_a(1'b1);
    pulse(3);
    rd(3'd2, v); check("R10 halted after B load", v, 16'd3);
    rd(3'd6, v); check("R10 run bit low", v & 16'h0200, 16'h0000);
    soft_trig();
    rd(3'd2, v); check("R7 soft restart clears", v, 16'd0);
    pulse(2);
    rd(3'd2, v); check("R7 restart releases halt", v, 16'd2);

    // R11 disable on B load
    wr(3'd0, 16'h0205);
    rd(3'd3, v);
    rd(3'd4, v);
    set_a(1'b0);
    pulse(1);
    set_a(1'b1);
    set_a(1'b0);
    set_a(1'b1);
    pulse(2);
    rd(3'd2, v); check("R11 disabled after B load", v, 16'd3);
    rd(3'd6, v); check("R11 enable bit low", v & 16'h0100, 16'h0000);
    soft_trig();
    pulse(1);
    rd(3'd2, v); check("R11 restart does not enable", v, 16'd0);
    wr(3'd1, 16'h0001);
    pulse(1);
    rd(3'd2, v); check("R11 enable command resumes", v, 16'd1);

    // R9 C compare restart
    wr(3'd0, 16'h0080);
    wr(3'd5, 16'd4);
    rd(3'd5, v); check("R9 C readback", v, 16'd4);
    soft_trig();
    rd(3'd6, v);
    pulse(4);
    rd(3'd6, v); check("R9 no C match yet", v & 16'h0010, 16'h0000);
    rd(3'd2, v); check("R9 count at C", v, 16'd4);
    pulse(1);
    rd(3'd2, v); check("R9 step at C restarts", v, 16'd0);
    rd(3'd6, v); check("R9 C match flag", v & 16'h0010, 16'h0010);

    // R8 external restart on input B rising
    wr(3'd0, 16'h0010);
    pulse(2);
    set_a(1'b0);
    set_a(1'b1);
    rd(3'd2, v); check("R8 unselected input ignored", v, 16'd2);
    rd(3'd6, v);
    set_b(1'b1);
    rd(3'd2, v); check("R8 external restart", v, 16'd0);
    rd(3'd6, v); check("R8 external flag", v & 16'h0080, 16'h0080);

    // R13 same-cycle read and event, R14 irq
    wr(3'd0, 16'h0001);
    wr(3'd7, 16'h0020);
    set_a(1'b0);
    soft_trig();
    rd(3'd6, v);
    check("R14 irq low with no flag", {15'd0, irq}, 16'd0);
    @(negedge clk); cap_a_in = 1'b1; addr = 3'd6; rd_en = 1'b1;
    #1 v = rdata;
    check("R13 read shows pre-event state", v & 16'h0020, 16'h0000);
    @(negedge clk); rd_en = 1'b0;
    #1 check("R14 irq on masked flag", {15'd0, irq}, 16'd1);
    rd(3'd6, v); check("R13 flag kept through same-cycle read", v & 16'h0020, 16'h0020);
    #1 check("R14 irq drops after read", {15'd0, irq}, 16'd0);
    rd(3'd6, v); check("R13 read cleared flags", v & 16'h00FF, 16'h0000);

    // R12 wrap
    wr(3'd0, 16'h0000);
    wr(3'd7, 16'h0000);
    soft_trig();
    rd(3'd6, v);
    pulse(65535);
    rd(3'd2, v); check("R12 top value", v, 16'hFFFF);
    rd(3'd6, v); check("R12 no wrap yet", v & 16'h0001, 16'h0000);
    pulse(1);
    rd(3'd2, v); check("R12 wrapped", v, 16'h0000);
    rd(3'd6, v); check("R12 wrap flag", v & 16'h0001, 16'h0001);

    finish_run();
  end
endmodule